// File: doc/BRIEF.md
# Supply Current Limit Tracker

This block watches a stream of sampled supply current readings and turns them into a cap on the hardware performance state. It holds two limits, and each one is enforced on its own. The first is a short-term limit. The block counts how many consecutive samples sit at or above a peak-current threshold. Once that run reaches a programmable length, it asks for the middle performance state.

The second is a long-term limit. A power-of-two exponential moving average of the samples is compared with a sustained-current threshold. While the average is above that threshold, the block asks for the lowest state. Once the average falls back, it asks for the middle state until the average drops below a release level. A load that hovers near the threshold therefore makes the cap alternate between the middle and lowest states.

Performance states are encoded as 1 (boost), 2 (middle) and 3 (low); a larger number is more restrictive. The cap is the larger of the two requests. Sticky event flags record both kinds of limit event until software clears them by writing a one.

Top module: `supply_current_limiter`

## Requirements
- R1: After reset, `pstate_cap` is 1, `avg_amps` is 0, and `peak_active`, `avg_active`, `peak_flag` and `avg_flag` are all 0.
- R2: On each clock with `smp_valid` high, an internal accumulator of SAMPLE_W+AVG_SHIFT bits is updated as acc = acc + sample - (acc >> AVG_SHIFT). `avg_amps` equals acc >> AVG_SHIFT. When `smp_valid` is low, the accumulator and `avg_amps` do not change.
- R3: `peak_active` rises after the clock that accepts the Nth consecutive valid sample with `smp_amps >= peak_limit`, where N = `peak_window` and N = 0 acts like 1. The run counter saturates at its maximum value. Any valid sample below `peak_limit` clears both the run and `peak_active` at that clock. Clocks without `smp_valid` leave both unchanged.
- R4: While `peak_active` is high, the short-term tracker requests state 2; otherwise it requests state 1.
- R5: `avg_active` is high exactly when `avg_amps > avg_limit`, and while it is high the long-term tracker requests state 3.
- R6: The long-term tracker becomes engaged at the first clock edge at which `avg_active` was high. It stays engaged until a clock edge at which `avg_amps <= avg_limit - HYST` (0 if negative). While engaged with `avg_active` low, it requests state 2; otherwise its request is 1 or 3 as R5 gives.
- R7: `pstate_cap` equals the larger of the two trackers' requests, and it is never 0.
- R8: `peak_flag` is set at a clock edge where `peak_active` was high. `avg_flag` is set at a clock edge where `avg_active` was high. A flag clears at a clock edge where its clear input is high. If set and clear occur at the same edge, set wins.
- R9: Under a sustained load above both thresholds, starting from reset, the cap moves from 1 to 2 and then to 3, and never moves back down while the load holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_amps | input | SAMPLE_W | Current sample in amperes, unsigned |
| peak_limit | input | SAMPLE_W | Short-term current threshold |
| peak_window | input | DUR_W | Allowed consecutive samples at or above peak_limit |
| avg_limit | input | SAMPLE_W | Sustained-current threshold for the average |
| clr_peak_flag | input | 1 | Write-one-to-clear for peak_flag |
| clr_avg_flag | input | 1 | Write-one-to-clear for avg_flag |
| pstate_cap | output | 2 | Most permissive allowed state: 1 boost, 2 middle, 3 low |
| avg_amps | output | SAMPLE_W | Current moving average |
| peak_active | output | 1 | Short-term limit being enforced |
| avg_active | output | 1 | Average above avg_limit |
| peak_flag | output | 1 | Sticky short-term event |
| avg_flag | output | 1 | Sticky long-term event |

## Verification
Several properties are checked on every cycle. The cap is never 0 and is at least as restrictive as each active tracker. A sample below the peak threshold releases the short-term limit at the next cycle. The average holds still without a strobe, and the flags stay set until they are cleared. Three things only the bench scenarios can show: the exact arithmetic of the average, the dither between states 2 and 3 as the average crosses the threshold and the release level, and the boost-middle-low progression under a sustained heavy load.

// File: rtl/supply_current_limiter.sv
module supply_current_limiter #(
  parameter int SAMPLE_W  = 8,
  parameter int AVG_SHIFT = 4,
  parameter int DUR_W     = 16,
  parameter int HYST      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_amps,
  input  logic [SAMPLE_W-1:0] peak_limit,
  input  logic [DUR_W-1:0]    peak_window,
  input  logic [SAMPLE_W-1:0] avg_limit,
  input  logic                clr_peak_flag,
  input  logic                clr_avg_flag,
  output logic [1:0]          pstate_cap,
  output logic [SAMPLE_W-1:0] avg_amps,
  output logic                peak_active,
  output logic                avg_active,
  output logic                peak_flag,
  output logic                avg_flag
);
  localparam int ACC_W = SAMPLE_W + AVG_SHIFT;
  localparam logic [1:0] PS_BOOST = 2'd1;
  localparam logic [1:0] PS_MID   = 2'd2;
  localparam logic [1:0] PS_LOW   = 2'd3;
  localparam logic [SAMPLE_W-1:0] HYST_V = SAMPLE_W'(HYST);

  logic [ACC_W-1:0] acc_q;
  logic [DUR_W-1:0] run_q;
  logic             expired_q;
  logic             engaged_q;

  logic [DUR_W-1:0]    run_inc;
  logic [SAMPLE_W-1:0] release_lvl;
  logic [1:0]          peak_req;
  logic [1:0]          avg_req;

  assign avg_amps    = acc_q[ACC_W-1:AVG_SHIFT];
  assign avg_active  = avg_amps > avg_limit;
  assign peak_active = expired_q;
  assign run_inc     = (&run_q) ? run_q : run_q + 1'b1;
  assign release_lvl = (avg_limit > HYST_V) ? avg_limit - HYST_V : '0;

  assign peak_req   = expired_q ? PS_MID : PS_BOOST;
  assign avg_req    = avg_active ? PS_LOW : (engaged_q ? PS_MID : PS_BOOST);
  assign pstate_cap = (avg_req > peak_req) ? avg_req : peak_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (smp_valid) begin
      acc_q <= acc_q + ACC_W'(smp_amps) - ACC_W'(avg_amps);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= '0;
      expired_q <= 1'b0;
    end else if (smp_valid) begin
      if (smp_amps >= peak_limit) begin
        run_q     <= run_inc;
        expired_q <= run_inc >= peak_window;
      end else begin
        run_q     <= '0;
        expired_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      engaged_q <= 1'b0;
    end else if (avg_active) begin
      engaged_q <= 1'b1;
    end else if (avg_amps <= release_lvl) begin
      engaged_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      peak_flag <= 1'b0;
      avg_flag  <= 1'b0;
    end else begin
      peak_flag <= (peak_flag & ~clr_peak_flag) | expired_q;
      avg_flag  <= (avg_flag & ~clr_avg_flag) | avg_active;
    end
  end
endmodule

// File: rtl/supply_current_limiter_chk.sv
module supply_current_limiter_chk #(
  parameter int SAMPLE_W = 8,
  parameter int DUR_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_amps,
  input logic [SAMPLE_W-1:0] peak_limit,
  input logic [DUR_W-1:0]    peak_window,
  input logic [SAMPLE_W-1:0] avg_limit,
  input logic                clr_peak_flag,
  input logic                clr_avg_flag,
  input logic [1:0]          pstate_cap,
  input logic [SAMPLE_W-1:0] avg_amps,
  input logic                peak_active,
  input logic                avg_active,
  input logic                peak_flag,
  input logic                avg_flag
);
  AST_CAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) pstate_cap != 2'd0); // R7
  AST_PEAK_CAPS_MID: assert property (@(posedge clk) disable iff (!rst_n) peak_active |-> pstate_cap >= 2'd2); // R4
  AST_AVG_CAPS_LOW: assert property (@(posedge clk) disable iff (!rst_n) avg_active |-> pstate_cap == 2'd3); // R5
  AST_COLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (smp_valid && smp_amps < peak_limit) |=> !peak_active); // R3
  AST_AVG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !smp_valid |=> $stable(avg_amps)); // R2
  AST_PEAK_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (peak_flag && !clr_peak_flag) |=> peak_flag); // R8
  AST_AVG_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) avg_active |=> avg_flag); // R8
endmodule

bind supply_current_limiter supply_current_limiter_chk #(.SAMPLE_W(SAMPLE_W), .DUR_W(DUR_W)) u_chk (.*);

// File: tb/tb_supply_current_limiter.sv
module tb_supply_current_limiter;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int SH = 4;
  localparam int DW = 16;
  localparam int HY = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic smp_valid = 0;
  logic [SW-1:0] smp_amps = 0, peak_limit = 200, avg_limit = 150;
  logic [DW-1:0] peak_window = 4;
  logic clr_peak_flag = 0, clr_avg_flag = 0;
  logic [1:0] pstate_cap;
  logic [SW-1:0] avg_amps;
  logic peak_active, avg_active, peak_flag, avg_flag;

  int checks = 0, failures = 0;
  int m_acc, m_run;
  bit m_exp, m_eng, m_pf, m_af;

  supply_current_limiter dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int mavg();
    return m_acc >> SH;
  endfunction

  function automatic int mcap();
    int p, a;
    p = m_exp ? 2 : 1;
    a = (mavg() > avg_limit) ? 3 : (m_eng ? 2 : 1);
    return (a > p) ? a : p;
  endfunction

  task automatic check(string tag);
    logic [13:0] act, exp;
    act = {pstate_cap, avg_amps, peak_active, avg_active, peak_flag, avg_flag};
    exp = {2'(mcap()), 8'(mavg()), m_exp, mavg() > avg_limit, m_pf, m_af};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int a, bit cp, bit ca, string tag);
    int rel, inc;
    bit over_pre;
    @(negedge clk);
    smp_valid = v; smp_amps = SW'(a); clr_peak_flag = cp; clr_avg_flag = ca;
    over_pre = mavg() > avg_limit;
    rel = (avg_limit > HY) ? avg_limit - HY : 0;
    @(posedge clk);
    m_pf = (m_pf & ~cp) | m_exp;
    m_af = (m_af & ~ca) | over_pre;
    if (over_pre) m_eng = 1; else if (mavg() <= rel) m_eng = 0;
    if (v) begin
      if (a >= peak_limit) begin
        inc = (m_run == 65535) ? m_run : m_run + 1;
        m_run = inc; m_exp = (inc >= peak_window);
      end else begin
        m_run = 0; m_exp = 0;
      end
      m_acc = m_acc + a - mavg();
    end
    #1;
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; smp_valid = 0; clr_peak_flag = 0; clr_avg_flag = 0;
    @(posedge clk); #1;
    m_acc = 0; m_run = 0; m_exp = 0; m_eng = 0; m_pf = 0; m_af = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed, lvl, prev;
    bit order_ok;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    do_reset();
    #1 check("R1 reset");

    // R3 peak run of window 3, then cold sample releases (R4 cap)
    peak_window = 3; peak_limit = 100; avg_limit = 250;
    step(1, 120, 0, 0, "R3 hot1");
    step(0, 0,   0, 0, "R3 gap");
    step(1, 100, 0, 0, "R3 hot2");
    step(1, 140, 0, 0, "R3 hot3 expire");
    if (!peak_active) begin failures++; $display("FAIL R3 actual=0 expected=1"); end
    checks++;
    step(1, 130, 0, 0, "R4 cap mid");
    step(1, 99,  0, 0, "R3 cold release");
    step(1, 10,  1, 0, "R8 clear");
    step(1, 10,  0, 0, "R8 cleared");
    // R3 window 0 acts as 1
    peak_window = 0;
    step(1, 200, 0, 0, "R3 window0");
    step(1, 20, 1, 1, "R8 set wins");

    // R2 hold without strobe
    step(0, 255, 0, 0, "R2 hold");

    // R9 sustained load: cap goes 1 -> 2 -> 3, never back
    do_reset();
    peak_limit = 200; peak_window = 4; avg_limit = 150;
    prev = 1; order_ok = 1;
    for (int i = 0; i < 60; i++) begin
      step(1, 250, 0, 0, "R9 sustained");
      if (pstate_cap < prev) order_ok = 0;
      prev = pstate_cap;
    end
    checks++;
    if (!order_ok || pstate_cap != 3) begin
      failures++; $display("FAIL R9 actual=%0d expected=3 monotonic", pstate_cap);
    end

    // R6 dither: light load lets average fall through limit and release
    for (int i = 0; i < 40; i++) step(1, 120, 0, 0, "R6 fall");
    // R5/R6 load hovering around the limit
    for (int i = 0; i < 80; i++) step(1, (i % 4 < 2) ? 190 : 110, 0, 0, "R6 hover");

    // random phase
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) begin
        peak_limit  = SW'($urandom_range(60, 220));
        peak_window = DW'($urandom_range(0, 12));
        avg_limit   = SW'($urandom_range(20, 200));
      end
      lvl = ($urandom_range(0, 9) < 6) ? $urandom_range(150, 255) : $urandom_range(0, 255);
      step($urandom_range(0, 3) != 0, lvl,
           $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0, "R2 R5 R6 R7 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule